// File: doc/BRIEF.md
# Configuration Address/Data Port Translator

This block turns host I/O port cycles into configuration read and write requests. Software first writes a 32-bit address word into a latch port. That word holds an enable flag, a bus number, a device number, a function number and a dword register index. Software then reads or writes a four-byte data window. The block combines the latched fields with the byte offset taken from the window port address. It moves the host data onto the correct byte lanes and issues one request to a downstream configuration target. It holds the host cycle until the target answers.

The host side uses right-justified data. A 1-, 2- or 4-byte access places its bytes in the low lanes of the host data bus. `io_be` gives the access width as 4'b0001, 4'b0011 or 4'b1111. The block shifts the bytes up to the dword lanes that the window offset selects. Configuration data is little-endian: window port +0 is bits 7:0 of the dword. The register index and the window offset together address 256 bytes per function.

A controller with three states sequences each access:
- `ST_IDLE` accepts a host access. It moves to `ST_WAIT_TGT` when the access is an enabled data-window access. For any other access it moves to `ST_RESP`.
- `ST_WAIT_TGT` holds the target request. It moves to `ST_RESP` when `tgt_ready` is high.
- `ST_RESP` marks completion for one cycle and then returns to `ST_IDLE`.

Top module: `cfg_port_xlat`

## Requirements
- R1: A host access with `io_be`=4'b1111 to port ADDR_PORT (default 0xCF8) writes the address latch or reads it back. The latch keeps bit 31 (enable), bits 23:16 (bus), bits 15:11 (device), bits 10:8 (function) and bits 7:2 (register index). Bits 30:24 and 1:0 read back as zero. Writing 0x80000000 reads back as exactly 0x80000000, and writing 0xFFFFFFFF reads back as 0x80FFFFFC.
- R2: An access to ports ADDR_PORT..ADDR_PORT+3 whose `io_be` is not 4'b1111 leaves the latch unchanged. When it is a read, it returns 0xFFFFFFFF.
- R3: A data-window access (ports DATA_PORT..DATA_PORT+3, default 0xCFC..0xCFF) made while the enable bit is set issues exactly one target request. The request carries `tgt_bus`, `tgt_dev`, `tgt_fn` and `tgt_reg` from the latch fields and `tgt_we` from the host access.
- R4: For a data-window write, with off = port - DATA_PORT, `tgt_be` is the low 4 bits of (`io_be` << off) and `tgt_wdata` is the low 32 bits of (`io_wdata` << 8*off). Bytes that would fall past lane 3 are dropped.
- R5: While the enable bit is clear, a data-window access issues no target request. A read returns 0xFFFFFFFF and a write changes no target data.
- R6: For a data-window read, `io_rdata` is the low 32 bits of ({32'hFFFFFFFF, `tgt_rdata`} >> 8*off). The read uses the `tgt_rdata` sampled when `tgt_ready` is high.
- R7: An access to any other port has no effect on the latch or the target. A read returns 0xFFFFFFFF.
- R8: `io_ready` is high only in `ST_IDLE`. `io_done` pulses for exactly one cycle per accepted access. For accesses that make no target request, the pulse comes one cycle after acceptance. For target accesses, it comes one cycle after the cycle in which `tgt_req` and `tgt_ready` are both high. `tgt_req` and its fields stay stable until `tgt_ready` is high.
- R9: After reset, `io_ready`=1, `io_done`=0 and `tgt_req`=0, and the latch reads 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_req | input | 1 | Host access strobe, taken when io_ready is high |
| io_we | input | 1 | 1 = write, 0 = read |
| io_port | input | IO_AW | Host port address |
| io_be | input | 4 | Right-justified access width mask |
| io_wdata | input | 32 | Right-justified write data |
| io_ready | output | 1 | Idle, able to take an access |
| io_done | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid while io_done is high |
| tgt_req | output | 1 | Configuration request to the target |
| tgt_we | output | 1 | Request is a write |
| tgt_bus | output | 8 | Bus number |
| tgt_dev | output | 5 | Device number |
| tgt_fn | output | 3 | Function number |
| tgt_reg | output | 6 | Dword register index |
| tgt_be | output | 4 | Lane enables within the dword |
| tgt_wdata | output | 32 | Lane-aligned write data |
| tgt_ready | input | 1 | Target accepts and completes the request |
| tgt_rdata | input | 32 | Target read dword, sampled with tgt_ready |

## Verification
The bench builds the block with its default parameters: a 16-bit port address, the latch at 0xCF8 and the window at 0xCFC. These defaults make every window offset reachable, including the top-lane clipping cases for words at +3 and dwords at +1..+3. The bench varies the target response delay from zero to three cycles, so `ST_WAIT_TGT` is seen both skipped through in one cycle and held for several. A behavioural model checks `io_ready`, `io_done` and `tgt_req` on every cycle of every access against the expected completion cycle.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

    localparam int NB      = 4;
    localparam int DW      = 8 * NB;
    localparam int OFF_W   = $clog2(NB);
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REG_W   = 6;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_TGT = 2'd1,
        ST_RESP     = 2'd2
    } xlat_state_t;

    typedef struct packed {
        logic             en;
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] reg_idx;
    } cfg_addr_t;

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
    import cfg_xlat_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_word,
    output cfg_addr_t     addr_q,
    output logic [DW-1:0] rd_word
);

    logic unused_rsvd;
    assign unused_rsvd = ^{wr_word[30:24], wr_word[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_en) begin
            addr_q.en      <= wr_word[31];
            addr_q.bus     <= wr_word[23:16];
            addr_q.dev     <= wr_word[15:11];
            addr_q.fn      <= wr_word[10:8];
            addr_q.reg_idx <= wr_word[7:2];
        end
    end

    always_comb begin
        rd_word        = '0;
        rd_word[31]    = addr_q.en;
        rd_word[23:16] = addr_q.bus;
        rd_word[15:11] = addr_q.dev;
        rd_word[10:8]  = addr_q.fn;
        rd_word[7:2]   = addr_q.reg_idx;
    end

    // Reserved bits can never be observed as set after a write (R1)
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_word[30:24] == 7'd0) && (rd_word[1:0] == 2'd0)
                  && (rd_word[31] == $past(wr_word[31])));

endmodule

// File: rtl/cfg_lane_steer.sv
module cfg_lane_steer
    import cfg_xlat_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  logic [NB-1:0]    be_in,
    input  logic [DW-1:0]    wdata_in,
    input  logic [DW-1:0]    rdata_in,
    output logic [NB-1:0]    be_out,
    output logic [DW-1:0]    wdata_out,
    output logic [DW-1:0]    rdata_out
);

    for (genvar j = 0; j < NB; j++) begin : g_lane
        logic       be_l;
        logic [7:0] wd_l;
        logic [7:0] rd_l;

        always_comb begin
            be_l = 1'b0;
            wd_l = 8'h00;
            rd_l = 8'hFF;
            for (int k = 0; k < NB; k++) begin
                if (k + int'(off) == j) begin
                    be_l = be_in[k];
                    wd_l = wdata_in[8*k +: 8];
                end
                if (j + int'(off) == k) begin
                    rd_l = rdata_in[8*k +: 8];
                end
            end
        end

        assign be_out[j]          = be_l;
        assign wdata_out[8*j +: 8] = wd_l;
        assign rdata_out[8*j +: 8] = rd_l;
    end

endmodule

// File: rtl/cfg_xact_fsm.sv
module cfg_xact_fsm
    import cfg_xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_req,
    input  logic        go_tgt,
    input  logic        tgt_ready,
    output xlat_state_t state_q,
    output logic        io_ready,
    output logic        io_done,
    output logic        tgt_req,
    output logic        accept,
    output logic        tgt_fire
);

    xlat_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (io_req) state_d = go_tgt ? ST_WAIT_TGT : ST_RESP;
            ST_WAIT_TGT: if (tgt_ready) state_d = ST_RESP;
            ST_RESP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        io_ready = (state_q == ST_IDLE);
        io_done  = (state_q == ST_RESP);
        tgt_req  = (state_q == ST_WAIT_TGT);
        accept   = io_ready && io_req;
        tgt_fire = tgt_req && tgt_ready;
    end

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_ready) |=> !io_ready);

    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> (io_ready && !io_done));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ready) |=> tgt_req);

endmodule

// File: rtl/cfg_port_xlat.sv
module cfg_port_xlat
    import cfg_xlat_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_we,
    input  logic [IO_AW-1:0] io_port,
    input  logic [NB-1:0]    io_be,
    input  logic [DW-1:0]    io_wdata,
    output logic             io_ready,
    output logic             io_done,
    output logic [DW-1:0]    io_rdata,
    output logic             tgt_req,
    output logic             tgt_we,
    output logic [BUS_W-1:0] tgt_bus,
    output logic [DEV_W-1:0] tgt_dev,
    output logic [FN_W-1:0]  tgt_fn,
    output logic [REG_W-1:0] tgt_reg,
    output logic [NB-1:0]    tgt_be,
    output logic [DW-1:0]    tgt_wdata,
    input  logic             tgt_ready,
    input  logic [DW-1:0]    tgt_rdata
);

    localparam int               BLK_W    = IO_AW - OFF_W;
    localparam logic [BLK_W-1:0] ADDR_BLK = ADDR_PORT[IO_AW-1:OFF_W];
    localparam logic [BLK_W-1:0] DATA_BLK = DATA_PORT[IO_AW-1:OFF_W];
    localparam logic [NB-1:0]    FULL_BE  = '1;
    localparam logic [DW-1:0]    ALL_ONES = '1;

    // Port decode of the access currently presented
    logic in_addr_blk, in_data_blk, latch_dw;
    assign in_addr_blk = (io_port[IO_AW-1:OFF_W] == ADDR_BLK);
    assign in_data_blk = (io_port[IO_AW-1:OFF_W] == DATA_BLK);
    assign latch_dw    = (io_port == ADDR_PORT) && (io_be == FULL_BE);

    cfg_addr_t     addr_q;
    logic [DW-1:0] latch_rd;
    logic          accept, tgt_fire, go_tgt;
    xlat_state_t   state_q;

    assign go_tgt = in_data_blk && addr_q.en;

    cfg_xact_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_req    (io_req),
        .go_tgt    (go_tgt),
        .tgt_ready (tgt_ready),
        .state_q   (state_q),
        .io_ready  (io_ready),
        .io_done   (io_done),
        .tgt_req   (tgt_req),
        .accept    (accept),
        .tgt_fire  (tgt_fire)
    );

    cfg_addr_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && io_we && latch_dw),
        .wr_word (io_wdata),
        .addr_q  (addr_q),
        .rd_word (latch_rd)
    );

    // Captured access attributes
    logic [OFF_W-1:0] off_q;
    logic [NB-1:0]    be_q;
    logic [DW-1:0]    wdata_q;
    logic             we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else if (accept) begin
            off_q   <= io_port[OFF_W-1:0];
            be_q    <= io_be;
            wdata_q <= io_wdata;
            we_q    <= io_we;
        end
    end

    logic [DW-1:0] rd_steered;

    cfg_lane_steer u_steer (
        .off       (off_q),
        .be_in     (be_q),
        .wdata_in  (wdata_q),
        .rdata_in  (tgt_rdata),
        .be_out    (tgt_be),
        .wdata_out (tgt_wdata),
        .rdata_out (rd_steered)
    );

    // Response word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_rdata <= '0;
        end else if (accept) begin
            io_rdata <= (latch_dw && !io_we) ? latch_rd : ALL_ONES;
        end else if (tgt_fire) begin
            io_rdata <= we_q ? ALL_ONES : rd_steered;
        end
    end

    assign tgt_we  = we_q;
    assign tgt_bus = addr_q.bus;
    assign tgt_dev = addr_q.dev;
    assign tgt_fn  = addr_q.fn;
    assign tgt_reg = addr_q.reg_idx;

    logic unused_blk;
    assign unused_blk = in_addr_blk;

    p_en_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> addr_q.en);

    p_be_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> (tgt_be != '0));

    p_fields_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ready) |=> ($stable(tgt_be) && $stable(tgt_wdata)
                                    && $stable(tgt_reg) && $stable(tgt_bus)));

    p_partial_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_addr_blk && (io_be != FULL_BE)) |=> $stable(latch_rd));

endmodule

// File: tb/cfg_port_xlat_test.sv
module cfg_port_xlat_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0, io_we = 1'b0;
    logic [15:0] io_port = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ready, io_done;
    logic [31:0] io_rdata;
    logic        tgt_req, tgt_we;
    logic [7:0]  tgt_bus;
    logic [4:0]  tgt_dev;
    logic [2:0]  tgt_fn;
    logic [5:0]  tgt_reg;
    logic [3:0]  tgt_be;
    logic [31:0] tgt_wdata;
    logic        tgt_ready = 1'b0;
    logic [31:0] tgt_rdata = '0;

    always #5 clk = ~clk;

    cfg_port_xlat uut (.*);

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Target memory model
    logic [31:0] tmem [int];
    logic [31:0] rmem [int];
    int lat = 0, wcnt = 0, req_seen = 0;
    logic [7:0] c_bus; logic [4:0] c_dev; logic [2:0] c_fn; logic [5:0] c_reg;
    logic [3:0] c_be; logic [31:0] c_wd; logic c_we;

    function automatic logic [31:0] seed_word(int k);
        return (k * 32'h01010101) ^ 32'hA5C30F1E;
    endfunction

    always @(negedge clk) begin
        if (tgt_req) begin
            if (wcnt == lat) begin
                int k;
                k = int'({tgt_bus, tgt_dev, tgt_fn, tgt_reg});
                if (!tmem.exists(k)) tmem[k] = seed_word(k);
                tgt_rdata = tmem[k];
                if (tgt_we)
                    for (int i = 0; i < 4; i++)
                        if (tgt_be[i]) tmem[k][8*i +: 8] = tgt_wdata[8*i +: 8];
                c_bus = tgt_bus; c_dev = tgt_dev; c_fn = tgt_fn; c_reg = tgt_reg;
                c_be = tgt_be; c_wd = tgt_wdata; c_we = tgt_we;
                req_seen++;
                tgt_ready = 1'b1;
                wcnt = 0;
            end else begin
                wcnt++;
                tgt_ready = 1'b0;
            end
        end else begin
            tgt_ready = 1'b0;
            wcnt = 0;
        end
    end

    // Reference helpers
    function automatic logic [31:0] ref_get(int k);
        if (!rmem.exists(k)) rmem[k] = seed_word(k);
        return rmem[k];
    endfunction

    function automatic logic [31:0] exp_read(logic [31:0] w, int off);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = (i + off < 4) ? w[8*(i+off) +: 8] : 8'hFF;
        return r;
    endfunction

    function automatic logic [3:0] exp_be(logic [3:0] be, int off);
        logic [3:0] r = '0;
        for (int i = 0; i < 4; i++) if (i + off < 4 && be[i]) r[i+off] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_wd(logic [31:0] wd, int off);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) if (i + off < 4) r[8*(i+off) +: 8] = wd[8*i +: 8];
        return r;
    endfunction

    // One host access with cycle-by-cycle comparison
    task automatic io_access(input bit we, input logic [15:0] port, input logic [3:0] be,
                             input logic [31:0] wd, input bit exp_tgt, input string tag,
                             output logic [31:0] rd);
        int done_at, seen0;
        done_at = exp_tgt ? lat + 2 : 1;
        seen0 = req_seen;
        @(negedge clk);
        chk(io_ready === 1'b1, {tag, " R8 io_ready idle"}, 32'(io_ready), 32'd1);
        io_req = 1'b1; io_we = we; io_port = port; io_be = be; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        for (int c = 1; c <= done_at; c++) begin
            if (c > 1) @(negedge clk);
            chk(tgt_req === (exp_tgt && c < done_at), {tag, " R8 tgt_req cycle"}, 32'(tgt_req), 32'(exp_tgt && c < done_at));
            chk(io_done === (c == done_at), {tag, " R8 io_done cycle"}, 32'(io_done), 32'(c == done_at));
            chk(io_ready === 1'b0, {tag, " R8 io_ready busy"}, 32'(io_ready), 32'd0);
        end
        rd = io_rdata;
        chk(req_seen - seen0 == (exp_tgt ? 1 : 0), {tag, " R3 R5 request count"}, 32'(req_seen - seen0), 32'(exp_tgt ? 1 : 0));
    endtask

    localparam logic [31:0] L1 = 32'h8003_2A44; // bus 3, dev 5, fn 2, reg 0x11
    int k1;

    initial begin : wdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd, w;
        k1 = int'({8'h03, 5'd5, 3'd2, 6'h11});
        repeat (3) @(negedge clk);
        chk(io_ready === 1'b1 && io_done === 1'b0 && tgt_req === 1'b0, "R9 reset outputs",
            {29'd0, io_ready, io_done, tgt_req}, 32'h4);
        rst_n = 1'b1;

        io_access(0, 16'hCF8, 4'hF, 0, 0, "R9 latch", rd);
        chk(rd === 32'h0, "R9 latch after reset", rd, 32'h0);

        io_access(1, 16'hCF8, 4'hF, 32'h8000_0000, 0, "R1 wr", rd);
        io_access(0, 16'hCF8, 4'hF, 0, 0, "R1 rd", rd);
        chk(rd === 32'h8000_0000, "R1 enable readback", rd, 32'h8000_0000);

        io_access(1, 16'hCF8, 4'hF, 32'hFFFF_FFFF, 0, "R1 wr", rd);
        io_access(0, 16'hCF8, 4'hF, 0, 0, "R1 rd", rd);
        chk(rd === 32'h80FF_FFFC, "R1 reserved bits zero", rd, 32'h80FF_FFFC);

        io_access(1, 16'hCF8, 4'hF, L1, 0, "R1 wr", rd);
        io_access(1, 16'hCF9, 4'h1, 32'h0000_00FF, 0, "R2 byte wr", rd);
        io_access(1, 16'hCF8, 4'h3, 32'h0000_FFFF, 0, "R2 word wr", rd);
        io_access(0, 16'hCFA, 4'h1, 0, 0, "R2 byte rd", rd);
        chk(rd === 32'hFFFF_FFFF, "R2 partial read ones", rd, 32'hFFFF_FFFF);
        io_access(0, 16'hCF8, 4'hF, 0, 0, "R2 rd", rd);
        chk(rd === L1, "R2 latch unchanged", rd, L1);

        // Dword read, zero wait
        lat = 0;
        io_access(0, 16'hCFC, 4'hF, 0, 1, "R6 dw", rd);
        w = ref_get(k1);
        chk(rd === exp_read(w, 0), "R6 dword read", rd, exp_read(w, 0));
        chk({c_bus, c_dev, c_fn, c_reg} === {8'h03, 5'd5, 3'd2, 6'h11}, "R3 fields",
            32'({c_bus, c_dev, c_fn, c_reg}), 32'({8'h03, 5'd5, 3'd2, 6'h11}));
        chk(c_be === 4'hF && c_we === 1'b0, "R4 dword be", {27'd0, c_we, c_be}, 32'hF);

        // Partial reads at every offset with several latencies
        for (int off = 0; off < 4; off++) begin
            lat = off;
            io_access(0, 16'hCFC + 16'(off), 4'h1, 0, 1, "R6 byte", rd);
            chk(rd === exp_read(w, off), "R6 byte read", rd, exp_read(w, off));
            chk(c_be === exp_be(4'h1, off), "R4 byte be", 32'(c_be), 32'(exp_be(4'h1, off)));
            io_access(0, 16'hCFC + 16'(off), 4'h3, 0, 1, "R6 word", rd);
            chk(rd === exp_read(w, off), "R6 word read", rd, exp_read(w, off));
            chk(c_be === exp_be(4'h3, off), "R4 word be", 32'(c_be), 32'(exp_be(4'h3, off)));
        end

        // Writes with lane steering
        lat = 1;
        io_access(1, 16'hCFF, 4'h1, 32'h0000_00C7, 1, "R4 bwr", rd);
        chk(c_be === 4'h8 && c_wd === 32'hC700_0000 && c_we === 1'b1, "R4 byte write lanes", c_wd, 32'hC700_0000);
        rmem[k1] = ref_get(k1); rmem[k1][31:24] = 8'hC7;
        lat = 3;
        io_access(1, 16'hCFD, 4'h3, 32'h0000_BEEF, 1, "R4 wwr", rd);
        chk(c_be === 4'h6 && c_wd === exp_wd(32'h0000_BEEF, 1), "R4 word write lanes", c_wd, exp_wd(32'h0000_BEEF, 1));
        rmem[k1][23:8] = 16'hBEEF;
        lat = 2;
        io_access(1, 16'hCFE, 4'hF, 32'h1122_3344, 1, "R4 clip", rd);
        chk(c_be === 4'hC && c_wd === exp_wd(32'h1122_3344, 2), "R4 clipped write", c_wd, exp_wd(32'h1122_3344, 2));
        rmem[k1][31:16] = 16'h3344;
        lat = 0;
        io_access(0, 16'hCFC, 4'hF, 0, 1, "R4 vrd", rd);
        chk(rd === rmem[k1], "R4 write result", rd, rmem[k1]);

        // Enable clear
        io_access(1, 16'hCF8, 4'hF, L1 & 32'h7FFF_FFFF, 0, "R5 dis", rd);
        io_access(0, 16'hCFC, 4'hF, 0, 0, "R5 rd", rd);
        chk(rd === 32'hFFFF_FFFF, "R5 disabled read ones", rd, 32'hFFFF_FFFF);
        io_access(1, 16'hCFC, 4'hF, 32'hDEAD_0000, 0, "R5 wr", rd);
        io_access(1, 16'hCF8, 4'hF, L1, 0, "R5 en", rd);
        io_access(0, 16'hCFC, 4'hF, 0, 1, "R5 vrd", rd);
        chk(rd === rmem[k1], "R5 write dropped", rd, rmem[k1]);

        // Other ports
        io_access(0, 16'h0080, 4'hF, 0, 0, "R7 rd", rd);
        chk(rd === 32'hFFFF_FFFF, "R7 unmapped read ones", rd, 32'hFFFF_FFFF);
        io_access(1, 16'h0CF4, 4'hF, 32'h0000_0000, 0, "R7 wr", rd);
        io_access(1, 16'hCFB, 4'h1, 32'h0000_0000, 0, "R7 wr", rd);
        io_access(0, 16'hCF8, 4'hF, 0, 0, "R7 rd", rd);
        chk(rd === L1, "R7 latch untouched", rd, L1);

        @(negedge clk);
        chk(io_ready === 1'b1 && tgt_req === 1'b0, "R8 final idle", {30'd0, io_ready, tgt_req}, 32'h2);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule